// File: doc/BRIEF.md
# Secure-Filtered Interrupt State Bitmaps

This block holds the enable, pending and active state of every external shared interrupt of an interrupt controller, one bit of each per interrupt. Software reaches each bitmap through a write-1-to-set view and a write-1-to-clear view of 32-bit words. The word at byte offset `o` inside a bitmap window covers interrupt IDs `8*o` to `8*o+31`. IDs below 32 belong to the per-core internal interrupts and are not stored. IDs at or above `NUM_IRQ` are not implemented.

Every access carries a secure attribute. Two per-interrupt settings decide which bits a non-secure access may touch. The first is a group bit, where 1 marks a non-secure interrupt. The second is a graded 2-bit non-secure permission field. A sticky control bit switches the security filtering off. The bank also watches the interrupt input lines. On edge-triggered interrupts it latches a pending bit on each rising edge. On level-sensitive interrupts it folds the live line level into the pending view. The enable, pending and active vectors are presented as outputs for the downstream selection logic.

Windows (byte address, 12 bits): control 0x000, group 0x080, set-enable 0x100, clear-enable 0x180, set-pending 0x200, clear-pending 0x280, set-active 0x300, clear-active 0x380, edge config 0x400, permission fields 0x800–0x8FF. All other addresses read zero and ignore writes.

Top module: `irq_state_bank`

## Requirements
- R1: A bitmap word whose first ID is below 32 or at/above `NUM_IRQ` (for example offset 0x000 or offset 4*(NUM_IRQ/32)) reads as zero, and writes to it change no state. Bits 31:0 of `irq_en`, `irq_pend` and `irq_act` are always zero.
- R2: A non-secure access made while the control bit is 0 is restricted. For it, the permitted-bit mask of a word is the group word ORed with a mask derived from the permission fields. Secure accesses, and any access made while the control bit is 1, are permitted on all 32 bits.
- R3: Writing to set-enable (0x100) sets each permitted bit written as 1. Writing to clear-enable (0x180) clears each permitted bit written as 1. Bits written as 0 are unchanged. Both views read the enable word ANDed with the group-only mask, and enable changes only on a bus write.
- R4: Set-pending (0x200) permits bits whose 2-bit field is nonzero (the OR of its two bits), both for writes and for reads. Clear-pending (0x280) permits bits whose field has its upper bit set (value 2 or 3), both for writes and for reads.
- R5: Writes to set-active (0x300) and clear-active (0x380) use the group-only mask. Reads of both active views use the mask whose field has its upper bit set.
- R6: The permission field of interrupt i occupies bits `2*(i%16)+1 : 2*(i%16)` of the word at 0x800 + 4*(i/16). These words are read and written only by secure accesses while the control bit is 0. Otherwise they read zero and writes are ignored.
- R7: The group bit of interrupt i is bit `i%32` of the word at 0x080 + 4*(i/32). A restricted access reads zero there and its writes are ignored.
- R8: The edge-config bit of interrupt i is bit `i%32` at 0x400 + 4*(i/32), where 1 means edge-triggered. Writes to it are masked by the group-only mask. For a level-sensitive interrupt (bit 0), the pending view and `irq_pend` are the latched bit ORed with the current line level.
- R9: A 0-to-1 transition of `irq_line[i]` sets the latched pending bit only if interrupt i is edge-triggered. A line that stays high, or any level-sensitive line, latches nothing.
- R10: If a rising edge and a clear-pending write for the same interrupt arrive in the same cycle, the pending bit ends up set.
- R11: Control bit 0 at 0x000 is the security-off bit. A secure write while it is 0 may set it. Once set, it stays 1 until reset and ignores every write. It reads back on every access.
- R12: Read data appears on `bus_rdata` at the clock edge that accepts the read, and holds its value until the next read.
- R13: After reset, all bitmaps, fields, the control bit and `bus_rdata` are zero, and all interrupts are level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | 1 = secure access |
| bus_rdata | output | 32 | Registered read data |
| irq_line | input | NUM_IRQ | Interrupt input lines, synchronous to `clk` |
| irq_en | output | NUM_IRQ | Enable bits per interrupt |
| irq_pend | output | NUM_IRQ | Effective pending state (latched OR level input) |
| irq_act | output | NUM_IRQ | Active bits per interrupt |

## Verification
The assertions assume that `irq_line` is already synchronous to `clk`, that an access lasts exactly one cycle with a stable address and attribute, and that addresses are word aligned. The stimulus changes the bus and the lines only on the falling edge and holds each access for one cycle. It uses only aligned addresses and keeps the interrupt count at a multiple of 32. The properties on enable and active state watch the first external word under secure writes. The same-cycle clash between a rising edge and a clear is set up by changing the line on the same falling edge that presents the clear.

// File: rtl/isb_pkg.sv
package isb_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 12;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CTRL,
        OP_GROUP,
        OP_EN_SET,
        OP_EN_CLR,
        OP_PD_SET,
        OP_PD_CLR,
        OP_AC_SET,
        OP_AC_CLR,
        OP_EDGE,
        OP_ACCF
    } isb_op_e;

    typedef struct packed {
        isb_op_e    op;
        logic [4:0] word;   // 32-interrupt word index
        logic       half;   // upper 16 interrupts of a permission pair
    } isb_dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] grp;   // group-only mask
        logic [WORD_W-1:0] lvl1;  // field >= 1
        logic [WORD_W-1:0] lvl2;  // field >= 2
    } isb_mask_t;

    function automatic isb_dec_t isb_decode(input logic [ADDR_W-1:0] a);
        isb_dec_t d;
        d.op   = OP_NONE;
        d.word = a[6:2];
        d.half = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (!a[11]) begin
                case (a[10:7])
                    4'd0: d.op = (a[6:2] == 5'd0) ? OP_CTRL : OP_NONE;
                    4'd1: d.op = OP_GROUP;
                    4'd2: d.op = OP_EN_SET;
                    4'd3: d.op = OP_EN_CLR;
                    4'd4: d.op = OP_PD_SET;
                    4'd5: d.op = OP_PD_CLR;
                    4'd6: d.op = OP_AC_SET;
                    4'd7: d.op = OP_AC_CLR;
                    4'd8: d.op = OP_EDGE;
                    default: d.op = OP_NONE;
                endcase
            end else if (a[10:8] == 3'd0) begin
                d.op   = OP_ACCF;
                d.word = a[7:3];
                d.half = a[2];
            end
        end
        return d;
    endfunction

    // per-interrupt: either field bit set
    function automatic logic [WORD_W-1:0] isb_fold_any(input logic [2*WORD_W-1:0] f);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = f[2*i] | f[2*i+1];
        return r;
    endfunction

    // per-interrupt: upper field bit set
    function automatic logic [WORD_W-1:0] isb_fold_hi(input logic [2*WORD_W-1:0] f);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = f[2*i+1];
        return r;
    endfunction

endpackage

// File: rtl/isb_perm.sv
module isb_perm
    import isb_pkg::*;
(
    input  logic [WORD_W-1:0]   grp_i,
    input  logic [2*WORD_W-1:0] accf_i,
    input  logic                secure_i,
    input  logic                sec_off_i,
    output isb_mask_t           mask_o
);

    logic restricted;
    assign restricted = !secure_i && !sec_off_i;

    always_comb begin
        if (restricted) begin
            mask_o.grp  = grp_i;
            mask_o.lvl1 = grp_i | isb_fold_any(accf_i);
            mask_o.lvl2 = grp_i | isb_fold_hi(accf_i);
        end else begin
            mask_o.grp  = '1;
            mask_o.lvl1 = '1;
            mask_o.lvl2 = '1;
        end
    end

endmodule

// File: rtl/isb_line_edge.sv
module isb_line_edge #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line_i;
    end

    assign rise_o = line_i & ~prev_q;

endmodule

// File: rtl/isb_word.sv
module isb_word
    import isb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  isb_op_e           op_i,
    input  logic              half_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              secure_i,
    input  logic              sec_off_i,
    input  logic [WORD_W-1:0] line_i,
    input  logic [WORD_W-1:0] rise_i,
    output logic [WORD_W-1:0] en_o,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] act_o,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0]   grp_q, en_q, pend_q, act_q, edge_q;
    logic [2*WORD_W-1:0] accf_q;
    logic [WORD_W-1:0]   pend_nx, pend_eff, rd_w;
    isb_mask_t           m;
    logic                wr_hit, cfg_ok, accf_ok;

    isb_perm u_perm (
        .grp_i     (grp_q),
        .accf_i    (accf_q),
        .secure_i  (secure_i),
        .sec_off_i (sec_off_i),
        .mask_o    (m)
    );

    assign wr_hit   = sel_i && wr_i;
    assign cfg_ok   = secure_i || sec_off_i;
    assign accf_ok  = secure_i && !sec_off_i;
    assign pend_eff = pend_q | (line_i & ~edge_q);

    always_comb begin
        pend_nx = pend_q;
        if (wr_hit && op_i == OP_PD_SET) pend_nx = pend_nx | (wdata_i & m.lvl1);
        if (wr_hit && op_i == OP_PD_CLR) pend_nx = pend_nx & ~(wdata_i & m.lvl2);
        pend_nx = pend_nx | (rise_i & edge_q);   // new edge wins over clear
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            edge_q <= '0;
            accf_q <= '0;
        end else begin
            pend_q <= pend_nx;
            if (wr_hit) begin
                case (op_i)
                    OP_GROUP:  if (cfg_ok) grp_q <= wdata_i;
                    OP_EN_SET: en_q  <= en_q | (wdata_i & m.grp);
                    OP_EN_CLR: en_q  <= en_q & ~(wdata_i & m.grp);
                    OP_AC_SET: act_q <= act_q | (wdata_i & m.grp);
                    OP_AC_CLR: act_q <= act_q & ~(wdata_i & m.grp);
                    OP_EDGE:   edge_q <= (edge_q & ~m.grp) | (wdata_i & m.grp);
                    OP_ACCF: begin
                        if (accf_ok) begin
                            if (half_i) accf_q[2*WORD_W-1:WORD_W] <= wdata_i;
                            else        accf_q[WORD_W-1:0]        <= wdata_i;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (op_i)
            OP_GROUP:             rd_w = cfg_ok ? grp_q : '0;
            OP_EN_SET, OP_EN_CLR: rd_w = en_q & m.grp;
            OP_PD_SET:            rd_w = pend_eff & m.lvl1;
            OP_PD_CLR:            rd_w = pend_eff & m.lvl2;
            OP_AC_SET, OP_AC_CLR: rd_w = act_q & m.lvl2;
            OP_EDGE:              rd_w = edge_q & m.grp;
            OP_ACCF:              rd_w = !accf_ok ? '0 :
                                         (half_i ? accf_q[2*WORD_W-1:WORD_W] : accf_q[WORD_W-1:0]);
            default:              rd_w = '0;
        endcase
    end

    assign rdata_o = sel_i ? rd_w : '0;
    assign en_o    = en_q;
    assign pend_o  = pend_eff;
    assign act_o   = act_q;

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import isb_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 96
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_vld,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               bus_sec,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_line,
    output logic [NUM_IRQ-1:0] irq_en,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic [NUM_IRQ-1:0] irq_act
);

    localparam int unsigned N_WORDS   = NUM_IRQ / WORD_W;
    localparam int unsigned EXT_WORDS = N_WORDS - 1;
    localparam int unsigned EXT_BITS  = EXT_WORDS * WORD_W;

    isb_dec_t          dec;
    logic              ds_q;
    logic [EXT_BITS-1:0] rise;
    logic [WORD_W-1:0] word_rd [EXT_WORDS];
    logic [WORD_W-1:0] rd_all;
    logic              unused_low;

    assign dec        = isb_decode(bus_addr);
    assign unused_low = ^irq_line[WORD_W-1:0];

    isb_line_edge #(.WIDTH(EXT_BITS)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (irq_line[NUM_IRQ-1:WORD_W]),
        .rise_o (rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q <= 1'b0;
        end else if (bus_vld && bus_we && dec.op == OP_CTRL && bus_sec && !ds_q) begin
            ds_q <= bus_wdata[0];
        end
    end

    assign irq_en[WORD_W-1:0]   = '0;
    assign irq_pend[WORD_W-1:0] = '0;
    assign irq_act[WORD_W-1:0]  = '0;

    for (genvar k = 0; k < EXT_WORDS; k++) begin : g_word
        logic sel;
        assign sel = bus_vld && (dec.word == 5'(k + 1));

        isb_word u_word (
            .clk       (clk),
            .rst       (rst),
            .sel_i     (sel),
            .wr_i      (bus_we),
            .op_i      (dec.op),
            .half_i    (dec.half),
            .wdata_i   (bus_wdata),
            .secure_i  (bus_sec),
            .sec_off_i (ds_q),
            .line_i    (irq_line[WORD_W*(k+1) +: WORD_W]),
            .rise_i    (rise[WORD_W*k +: WORD_W]),
            .en_o      (irq_en[WORD_W*(k+1) +: WORD_W]),
            .pend_o    (irq_pend[WORD_W*(k+1) +: WORD_W]),
            .act_o     (irq_act[WORD_W*(k+1) +: WORD_W]),
            .rdata_o   (word_rd[k])
        );
    end

    always_comb begin
        rd_all = (dec.op == OP_CTRL) ? {{(WORD_W-1){1'b0}}, ds_q} : '0;
        for (int k = 0; k < EXT_WORDS; k++) rd_all = rd_all | word_rd[k];
    end

    always_ff @(posedge clk) begin
        if (rst)                   bus_rdata <= '0;
        else if (bus_vld && !bus_we) bus_rdata <= rd_all;
    end

endmodule

// File: rtl/isb_chk.sv
module isb_chk #(
    parameter int unsigned NUM_IRQ = 96
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_vld,
    input logic               bus_we,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_sec,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic [NUM_IRQ-1:0] irq_act,
    input logic               ds_q
);

    localparam logic [11:0] A_ENS1 = 12'h104;
    localparam logic [11:0] A_ENC1 = 12'h184;
    localparam logic [11:0] A_ACS1 = 12'h304;

    logic wr_w;
    assign wr_w = bus_vld && bus_we;

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_w && bus_sec && bus_addr == A_ENS1)
        |=> ((irq_en[63:32] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_w && bus_sec && bus_addr == A_ENC1)
        |=> ((irq_en[63:32] & $past(bus_wdata)) == 32'h0));

    // R3
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_w |=> $stable(irq_en));

    // R5
    act_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_w && bus_sec && bus_addr == A_ACS1)
        |=> ((irq_act[63:32] & $past(bus_wdata)) == $past(bus_wdata)));

    // R11
    ds_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ds_q |=> ds_q);

endmodule

bind irq_state_bank isb_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_sec   (bus_sec),
    .irq_en    (irq_en),
    .irq_act   (irq_act),
    .ds_q      (ds_q)
);

// File: tb/irq_state_bank_tb_top.sv
module irq_state_bank_tb_top;

    localparam int unsigned NUM_IRQ = 96;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_vld = 1'b0;
    logic               bus_we = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_sec = 1'b0;
    logic [31:0]        bus_rdata;
    logic [NUM_IRQ-1:0] irq_line = '0;
    logic [NUM_IRQ-1:0] irq_en, irq_pend, irq_act;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    irq_state_bank #(.NUM_IRQ(NUM_IRQ)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_vld   (bus_vld),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_sec   (bus_sec),
        .bus_rdata (bus_rdata),
        .irq_line  (irq_line),
        .irq_en    (irq_en),
        .irq_pend  (irq_pend),
        .irq_act   (irq_act)
    );

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_vld = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_sec = s;
        @(negedge clk);
        bus_vld = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic s, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_vld = 1'b1; bus_we = 1'b0; bus_addr = a; bus_sec = s;
        sb_q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_vld = 1'b0;
    endtask

    // monitor: compare registered read data after the accepting edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_vld && !bus_we) begin
                #2;
                if (sb_q.size() == 0) begin
                    check("scoreboard underflow", 96'd1, 96'd0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(it.tag, {64'h0, bus_rdata}, {64'h0, it.exp});
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check("R13 enable vector", irq_en, '0);
        check("R13 pending vector", irq_pend, '0);
        check("R13 active vector", irq_act, '0);
        check("R13 read data", {64'h0, bus_rdata}, 96'h0);
        rd(12'h104, 1'b1, 32'h0, "R13 enable word after reset");

        // R3 secure enable set/clear
        wr(12'h104, 32'hF0F0_1234, 1'b1);
        rd(12'h104, 1'b1, 32'hF0F0_1234, "R3 set view");
        rd(12'h184, 1'b1, 32'hF0F0_1234, "R3 clear view same state");
        wr(12'h184, 32'h0000_1200, 1'b1);
        rd(12'h104, 1'b1, 32'hF0F0_0034, "R3 after clear");

        // R1 internal and unimplemented words
        wr(12'h100, 32'hFFFF_FFFF, 1'b1);
        wr(12'h10C, 32'hFFFF_FFFF, 1'b1);
        rd(12'h100, 1'b1, 32'h0, "R1 internal word reads zero");
        rd(12'h10C, 1'b1, 32'h0, "R1 unimplemented word reads zero");
        check("R1 enable vector unchanged", irq_en, {32'h0, 32'hF0F0_0034, 32'h0});

        // R2 R7 group filtering of non-secure accesses
        wr(12'h108, 32'hFFFF_FFFF, 1'b0);
        check("R2 non-secure write to secure group ignored", irq_en[95:64], 32'h0);
        rd(12'h104, 1'b0, 32'h0, "R2 non-secure read all-secure word");
        wr(12'h084, 32'h0000_FFFF, 1'b1);
        rd(12'h084, 1'b0, 32'h0, "R7 non-secure group read");
        wr(12'h084, 32'h0, 1'b0);
        rd(12'h084, 1'b1, 32'h0000_FFFF, "R7 secure group read, non-secure write ignored");
        rd(12'h104, 1'b0, 32'h0000_0034, "R2 non-secure enable read masked");
        wr(12'h184, 32'hFFFF_FFFF, 1'b0);
        rd(12'h104, 1'b1, 32'hF0F0_0000, "R3 non-secure clear limited to group");

        // R6 permission fields: irq48=1, irq49=2, irq50=3
        wr(12'h80C, 32'h0000_0039, 1'b1);
        rd(12'h80C, 1'b1, 32'h0000_0039, "R6 secure field read");
        rd(12'h80C, 1'b0, 32'h0, "R6 non-secure field read");
        wr(12'h80C, 32'h0, 1'b0);
        rd(12'h80C, 1'b1, 32'h0000_0039, "R6 non-secure field write ignored");

        // R4 pending thresholds
        wr(12'h204, 32'hFFFF_FFFF, 1'b0);
        rd(12'h204, 1'b1, 32'h0007_FFFF, "R4 set-pending threshold one");
        rd(12'h284, 1'b0, 32'h0006_FFFF, "R4 clear-pending view threshold two");
        wr(12'h284, 32'hFFFF_FFFF, 1'b0);
        rd(12'h204, 1'b1, 32'h0001_0000, "R4 clear-pending threshold two");
        check("R4 pending vector", irq_pend[63:32], 32'h0001_0000);

        // R5 active
        wr(12'h304, 32'hFFFF_FFFF, 1'b0);
        rd(12'h304, 1'b1, 32'h0000_FFFF, "R5 non-secure set group only");
        wr(12'h304, 32'h0003_0000, 1'b1);
        rd(12'h304, 1'b0, 32'h0002_FFFF, "R5 non-secure read threshold two");
        wr(12'h384, 32'h0003_0000, 1'b0);
        rd(12'h384, 1'b1, 32'h0003_FFFF, "R5 non-secure clear group only");
        check("R5 active vector", irq_act[63:32], 32'h0003_FFFF);

        // R8 level-sensitive pending merge (irq70)
        @(negedge clk);
        irq_line[70] = 1'b1;
        #1;
        check("R8 level merges into pending output", {95'h0, irq_pend[70]}, 96'h1);
        rd(12'h208, 1'b1, 32'h0000_0040, "R8 level read");
        @(negedge clk);
        irq_line[70] = 1'b0;
        rd(12'h208, 1'b1, 32'h0, "R8 level not latched");

        // R9 edge-triggered irq72
        wr(12'h408, 32'h0000_0100, 1'b1);
        rd(12'h408, 1'b1, 32'h0000_0100, "R8 edge config read");
        @(negedge clk);
        irq_line[72] = 1'b1;
        @(negedge clk);
        irq_line[72] = 1'b0;
        rd(12'h208, 1'b1, 32'h0000_0100, "R9 rising edge latched");
        wr(12'h288, 32'h0000_0100, 1'b1);
        rd(12'h208, 1'b1, 32'h0, "R9 cleared");
        @(negedge clk);
        irq_line[72] = 1'b1;
        @(negedge clk);
        wr(12'h288, 32'h0000_0100, 1'b1);
        rd(12'h208, 1'b1, 32'h0, "R9 steady high latches nothing");
        check("R9 pending output", {95'h0, irq_pend[72]}, 96'h0);

        // R10 edge and clear in the same cycle
        @(negedge clk);
        irq_line[72] = 1'b0;
        @(negedge clk);
        irq_line[72] = 1'b1;
        bus_vld = 1'b1; bus_we = 1'b1; bus_addr = 12'h288; bus_wdata = 32'h0000_0100; bus_sec = 1'b1;
        @(negedge clk);
        bus_vld = 1'b0; bus_we = 1'b0;
        rd(12'h208, 1'b1, 32'h0000_0100, "R10 edge wins over clear");

        // R12 read data registered
        rd(12'h000, 1'b1, 32'h0, "R12 control read");
        @(negedge clk);
        bus_vld = 1'b1; bus_we = 1'b0; bus_addr = 12'h304; bus_sec = 1'b1;
        sb_q.push_back('{exp: 32'h0003_FFFF, tag: "R12 registered read"});
        #1;
        check("R12 read data waits for the edge", {64'h0, bus_rdata}, 96'h0);
        @(negedge clk);
        bus_vld = 1'b0;
        @(negedge clk);
        check("R12 read data held", {64'h0, bus_rdata}, {64'h0, 32'h0003_FFFF});

        // R11 security-off bit
        wr(12'h000, 32'h1, 1'b0);
        rd(12'h000, 1'b1, 32'h0, "R11 non-secure cannot set");
        wr(12'h000, 32'h1, 1'b1);
        rd(12'h000, 1'b0, 32'h1, "R11 set and visible");
        rd(12'h304, 1'b0, 32'h0003_FFFF, "R2 unfiltered when security off");
        rd(12'h80C, 1'b1, 32'h0, "R6 fields hidden when security off");
        wr(12'h000, 32'h0, 1'b1);
        rd(12'h000, 1'b1, 32'h1, "R11 sticky");
        wr(12'h084, 32'h0000_00F0, 1'b0);
        rd(12'h084, 1'b0, 32'h0000_00F0, "R7 group open when security off");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 96'(sb_q.size()), 96'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule